// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control state of a small processor core: the status word, the exception program counter, the faulting address, the trap vector, the cause code, the page-table base, a free-running retired-instruction counter with its compare value, an inter-processor-interrupt control register, and two mailbox registers for talking to a host. Software reaches the registers through one combinational read port and one write port. In the cycle of a write, the write port returns the value the addressed register held before that write.

Most registers have a side effect when written. A status write leaves the interrupt-pending field as it was. Writing compare clears the timer interrupt. The outbound mailbox accepts a new value only while it holds zero. A write to the inbound mailbox raises or drops the host interrupt. The counter advances each cycle by the number of instructions retired, and it raises the timer interrupt when it reaches compare. The pending field is driven to the interrupt-taking logic, which lies outside this block.

Top module: `pcr_file`

## Requirements
- R1: After reset, status reads 0x00000001 (supervisor bit 0 set), every other index reads 0 and `pend_out` is 0.
- R2: Indices are 0 status, 1 EPC, 2 badvaddr, 3 vector, 4 count, 5 compare, 6 cause, 7 page-table base, 8 IPI control, 9 outbound mailbox, 10 inbound mailbox. Index 8 and indices 11 to 15 read as 0. A write to indices 11 to 15 changes nothing.
- R3: During a write cycle, `wr_old` shows the value the addressed register held before the write, as a read would return it.
- R4: Status bits 23:16 are the pending field. A status write never changes them, and a status read returns them merged with the stored bits. Bits 31:24 read as 0.
- R5: With the default parameters, status bits 4 (FPU enable), 5 (vector enable), 6 and 7 (64-bit modes) are forced to 0 on every write. Bits 3:0 and 15:8 are writable, so writing all ones to status gives 0x0000FF0F plus the pending field.
- R6: Unless it is written, count advances each cycle by `retire_cnt`, modulo 2^32.
- R7: The timer pending bit (irq 7, status bit 23) is set when the old count is below compare and the old count plus `retire_cnt` is greater than or equal to compare. The sum is taken without wrap.
- R8: A compare write stores the value and clears the timer pending bit. In the same cycle it takes priority over a timer event.
- R9: A count write stores `wr_data`. It wins over the same-cycle increment, and no timer event is raised in that cycle.
- R10: A page-table-base write clears bits 11:0 of the stored value.
- R11: A write to index 8 sets the IPI pending bit (irq 5, status bit 21) to `wr_data[0]`.
- R12: A write to the outbound mailbox takes effect only while it holds zero.
- R13: A write to the inbound mailbox stores the value and sets the host pending bit (irq 6, status bit 22) when the value is nonzero, or clears it when the value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 4 | Read index |
| rd_data | output | 32 | Read value (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write index |
| wr_data | input | 32 | Write value |
| wr_old | output | 32 | Value held by the addressed register before the write |
| retire_cnt | input | 4 | Instructions retired this cycle |
| pend_out | output | 8 | Interrupt-pending field |

## Verification
The checker watches the per-write side effects on every cycle: the outbound mailbox holds while nonzero, compare clears the timer bit, status writes leave the pending field alone, count and IPI writes land, and the inbound mailbox sets the host bit from its value. It also checks the invariants of the forced-zero status bits and the page alignment of the base register. Only the bench scenarios can show the threshold test of the timer, which needs the count to approach compare from below. The same holds for the precedence of writes over same-cycle increments and for the exact values returned as old data.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int PEND_W  = 8;
    localparam int PEND_LO = 16;
    localparam int MASK_LO = 8;

    localparam int IRQ_IPI   = 5;
    localparam int IRQ_HOST  = 6;
    localparam int IRQ_TIMER = 7;

    localparam int SB_SUP  = 0;
    localparam int SB_PSUP = 1;
    localparam int SB_EI   = 2;
    localparam int SB_PEI  = 3;
    localparam int SB_FPU  = 4;
    localparam int SB_VEC  = 5;
    localparam int SB_U64  = 6;
    localparam int SB_S64  = 7;

    localparam logic [AW-1:0] IX_STATUS = 4'd0;
    localparam logic [AW-1:0] IX_EPC    = 4'd1;
    localparam logic [AW-1:0] IX_BADVA  = 4'd2;
    localparam logic [AW-1:0] IX_VECTOR = 4'd3;
    localparam logic [AW-1:0] IX_COUNT  = 4'd4;
    localparam logic [AW-1:0] IX_CMP    = 4'd5;
    localparam logic [AW-1:0] IX_CAUSE  = 4'd6;
    localparam logic [AW-1:0] IX_PTBASE = 4'd7;
    localparam logic [AW-1:0] IX_IPI    = 4'd8;
    localparam logic [AW-1:0] IX_TOHOST = 4'd9;
    localparam logic [AW-1:0] IX_FRHOST = 4'd10;

    typedef struct packed {
        logic [DW-1:0]     stat;
        logic [PEND_W-1:0] pend;
        logic [DW-1:0]     epc;
        logic [DW-1:0]     badva;
        logic [DW-1:0]     vector;
        logic [DW-1:0]     count;
        logic [DW-1:0]     cmp;
        logic [DW-1:0]     cause;
        logic [DW-1:0]     ptbase;
        logic [DW-1:0]     tohost;
        logic [DW-1:0]     frhost;
    } pcr_state_t;

    function automatic logic [DW-1:0] stat_wmask(bit fpu, bit vec, bit m64);
        logic [DW-1:0] m;
        m = '0;
        m[SB_SUP]  = 1'b1;
        m[SB_PSUP] = 1'b1;
        m[SB_EI]   = 1'b1;
        m[SB_PEI]  = 1'b1;
        m[SB_FPU]  = fpu;
        m[SB_VEC]  = vec;
        m[SB_U64]  = m64;
        m[SB_S64]  = m64;
        m[MASK_LO +: PEND_W] = '1;
        return m;
    endfunction
endpackage

// File: rtl/pcr_timer.sv
module pcr_timer #(
    parameter int DW    = 32,
    parameter int RET_W = 4
) (
    input  logic [DW-1:0]    count_q,
    input  logic [DW-1:0]    cmp_q,
    input  logic [RET_W-1:0] inc,
    output logic [DW-1:0]    count_next,
    output logic             fire
);
    localparam int SW = DW + 1;
    logic [SW-1:0] sum;

    always_comb begin
        sum        = {1'b0, count_q} + SW'(inc);
        count_next = sum[DW-1:0];
        fire       = (count_q < cmp_q) && (sum >= {1'b0, cmp_q});
    end
endmodule

// File: rtl/pcr_pending.sv
module pcr_pending #(
    parameter int N         = 8,
    parameter int IRQ_TIMER = 7,
    parameter int IRQ_IPI   = 5,
    parameter int IRQ_HOST  = 6
) (
    input  logic [N-1:0] pend_q,
    input  logic         timer_fire,
    input  logic         cmp_wr,
    input  logic         ipi_wr,
    input  logic         ipi_val,
    input  logic         host_wr,
    input  logic         host_val,
    output logic [N-1:0] pend_d
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == IRQ_TIMER) begin : g_timer
            always_comb begin
                pend_d[i] = pend_q[i];
                if (timer_fire) pend_d[i] = 1'b1;
                if (cmp_wr)     pend_d[i] = 1'b0;
            end
        end else if (i == IRQ_IPI) begin : g_ipi
            always_comb pend_d[i] = ipi_wr ? ipi_val : pend_q[i];
        end else if (i == IRQ_HOST) begin : g_host
            always_comb pend_d[i] = host_wr ? host_val : pend_q[i];
        end else begin : g_hold
            always_comb pend_d[i] = pend_q[i];
        end
    end
endmodule

// File: rtl/pcr_read_mux.sv
module pcr_read_mux
    import pcr_pkg::*;
(
    input  pcr_state_t    st,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    logic [DW-1:0] stat_view;

    always_comb begin
        stat_view = st.stat;
        stat_view[PEND_LO +: PEND_W] = st.pend;
        case (addr)
            IX_STATUS: data = stat_view;
            IX_EPC:    data = st.epc;
            IX_BADVA:  data = st.badva;
            IX_VECTOR: data = st.vector;
            IX_COUNT:  data = st.count;
            IX_CMP:    data = st.cmp;
            IX_CAUSE:  data = st.cause;
            IX_PTBASE: data = st.ptbase;
            IX_TOHOST: data = st.tohost;
            IX_FRHOST: data = st.frhost;
            default:   data = '0;
        endcase
    end
endmodule

// File: rtl/pcr_file.sv
module pcr_file
    import pcr_pkg::*;
#(
    parameter int RET_W     = 4,
    parameter int PAGE_BITS = 12,
    parameter bit HAS_FPU   = 1'b0,
    parameter bit HAS_VEC   = 1'b0,
    parameter bit HAS_64    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     wr_old,
    input  logic [RET_W-1:0]  retire_cnt,
    output logic [PEND_W-1:0] pend_out
);
    localparam logic [DW-1:0] WMASK     = stat_wmask(HAS_FPU, HAS_VEC, HAS_64);
    localparam logic [DW-1:0] PAGE_MASK = ~((DW'(1) << PAGE_BITS) - DW'(1));
    localparam pcr_state_t    RST_ST    = '{stat: DW'(1) << SB_SUP, default: '0};

    pcr_state_t st_q, st_d;

    logic [DW-1:0]     count_inc;
    logic              raw_fire;
    logic              timer_fire;
    logic [PEND_W-1:0] pend_d;
    logic              wr_count, wr_cmp, wr_ipi, wr_frhost;

    assign wr_count  = wr_en && (wr_addr == IX_COUNT);
    assign wr_cmp    = wr_en && (wr_addr == IX_CMP);
    assign wr_ipi    = wr_en && (wr_addr == IX_IPI);
    assign wr_frhost = wr_en && (wr_addr == IX_FRHOST);
    assign timer_fire = raw_fire && !wr_count;

    pcr_timer #(.DW(DW), .RET_W(RET_W)) u_timer (
        .count_q    (st_q.count),
        .cmp_q      (st_q.cmp),
        .inc        (retire_cnt),
        .count_next (count_inc),
        .fire       (raw_fire)
    );

    pcr_pending #(
        .N(PEND_W), .IRQ_TIMER(IRQ_TIMER), .IRQ_IPI(IRQ_IPI), .IRQ_HOST(IRQ_HOST)
    ) u_pend (
        .pend_q     (st_q.pend),
        .timer_fire (timer_fire),
        .cmp_wr     (wr_cmp),
        .ipi_wr     (wr_ipi),
        .ipi_val    (wr_data[0]),
        .host_wr    (wr_frhost),
        .host_val   (wr_data != '0),
        .pend_d     (pend_d)
    );

    pcr_read_mux u_rd  (.st(st_q), .addr(rd_addr), .data(rd_data));
    pcr_read_mux u_old (.st(st_q), .addr(wr_addr), .data(wr_old));

    always_comb begin
        st_d       = st_q;
        st_d.count = count_inc;
        st_d.pend  = pend_d;
        if (wr_en) begin
            case (wr_addr)
                IX_STATUS: st_d.stat   = wr_data & WMASK;
                IX_EPC:    st_d.epc    = wr_data;
                IX_BADVA:  st_d.badva  = wr_data;
                IX_VECTOR: st_d.vector = wr_data;
                IX_COUNT:  st_d.count  = wr_data;
                IX_CMP:    st_d.cmp    = wr_data;
                IX_CAUSE:  st_d.cause  = wr_data;
                IX_PTBASE: st_d.ptbase = wr_data & PAGE_MASK;
                IX_TOHOST: if (st_q.tohost == '0) st_d.tohost = wr_data;
                IX_FRHOST: st_d.frhost = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign pend_out = st_q.pend;
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker
    import pcr_pkg::*;
#(
    parameter logic [DW-1:0] WMASK     = '0,
    parameter int            PAGE_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [PEND_W-1:0] pend_out,
    input logic              timer_fire,
    input logic [DW-1:0]     stat_q,
    input logic [DW-1:0]     tohost_q,
    input logic [DW-1:0]     count_q,
    input logic [DW-1:0]     ptbase_q
);
    AST_TOHOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IX_TOHOST && tohost_q != '0) |=> tohost_q == $past(tohost_q)); // R12
    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IX_CMP) |=> !pend_out[IRQ_TIMER]); // R8
    AST_STATUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IX_STATUS && !timer_fire) |=> pend_out == $past(pend_out)); // R4
    AST_FORCED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~WMASK) == '0); // R5
    AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ptbase_q[PAGE_BITS-1:0] == '0); // R10
    AST_HOST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IX_FRHOST) |=> pend_out[IRQ_HOST] == ($past(wr_data) != '0)); // R13
    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IX_COUNT) |=> count_q == $past(wr_data)); // R9
    AST_IPI_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IX_IPI) |=> pend_out[IRQ_IPI] == $past(wr_data[0])); // R11
endmodule

bind pcr_file pcr_checker #(.WMASK(WMASK), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pend_out   (pend_out),
    .timer_fire (timer_fire),
    .stat_q     (st_q.stat),
    .tohost_q   (st_q.tohost),
    .count_q    (st_q.count),
    .ptbase_q   (st_q.ptbase)
);

// File: tb/test_pcr_file.sv
module test_pcr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_old;
    logic [3:0]  retire_cnt = '0;
    logic [7:0]  pend_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pcr_file i_pcr_file (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_old(wr_old),
        .retire_cnt(retire_cnt), .pend_out(pend_out)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        we;
        logic [3:0]  a;
        logic [31:0] d;
        logic [3:0]  inc;
        logic [31:0] old;
        logic [3:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{8'd3,  1'b1, 4'd1,  32'h12345678, 4'd0, 32'h0,        4'd1,  32'h12345678}, // R3
        '{8'd3,  1'b1, 4'd1,  32'hAAAA0000, 4'd0, 32'h12345678, 4'd1,  32'hAAAA0000}, // R3
        '{8'd5,  1'b1, 4'd0,  32'hFFFFFFFF, 4'd0, 32'h00000001, 4'd0,  32'h0000FF0F}, // R5
        '{8'd10, 1'b1, 4'd7,  32'hDEADBEEF, 4'd0, 32'h0,        4'd7,  32'hDEADB000}, // R10
        '{8'd2,  1'b1, 4'd5,  32'd10,       4'd0, 32'h0,        4'd5,  32'd10},       // R2
        '{8'd6,  1'b0, 4'd0,  32'h0,        4'd7, 32'h0,        4'd4,  32'd7},        // R6
        '{8'd7,  1'b0, 4'd0,  32'h0,        4'd3, 32'h0,        4'd0,  32'h0080FF0F}, // R7
        '{8'd6,  1'b0, 4'd0,  32'h0,        4'd5, 32'h0,        4'd4,  32'd15},       // R6
        '{8'd8,  1'b1, 4'd5,  32'd20,       4'd0, 32'd10,       4'd0,  32'h0000FF0F}, // R8
        '{8'd11, 1'b1, 4'd8,  32'h1,        4'd0, 32'h0,        4'd0,  32'h0020FF0F}, // R11
        '{8'd13, 1'b1, 4'd10, 32'h55,       4'd0, 32'h0,        4'd0,  32'h0060FF0F}, // R13
        '{8'd12, 1'b1, 4'd9,  32'h9,        4'd0, 32'h0,        4'd9,  32'h9},        // R12
        '{8'd12, 1'b1, 4'd9,  32'h7,        4'd0, 32'h9,        4'd9,  32'h9},        // R12
        '{8'd2,  1'b1, 4'd12, 32'hFFFF,     4'd0, 32'h0,        4'd12, 32'h0},        // R2
        '{8'd4,  1'b1, 4'd0,  32'h0,        4'd0, 32'h0060FF0F, 4'd0,  32'h00600000}, // R4
        '{8'd13, 1'b1, 4'd10, 32'h0,        4'd0, 32'h55,       4'd0,  32'h00200000}, // R13
        '{8'd11, 1'b1, 4'd8,  32'h2,        4'd0, 32'h0,        4'd0,  32'h00000000}  // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] inc, input logic [3:0] ra, output logic [31:0] old);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; retire_cnt = inc; rd_addr = ra;
        #1 old = wr_old;
        @(posedge clk);
        #1 wr_en = 1'b0; retire_cnt = '0;
        #1;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] old;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 / R2: reset values and the read map
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) rd_addr = 4'(i);
            #1 check($sformatf("R1 reset index %0d", i), rd_data, (i == 0) ? 32'h1 : 32'h0);
        end
        check("R1 pend_out after reset", {24'h0, pend_out}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            step(VT[v].we, VT[v].a, VT[v].d, VT[v].inc, VT[v].ra, old);
            if (VT[v].we) check($sformatf("R3 old value row %0d (R%0d)", v, VT[v].req), old, VT[v].old);
            check($sformatf("R%0d read row %0d", VT[v].req, v), rd_data, VT[v].exp);
        end

        // R9: count write beats a same-cycle increment that would hit compare (15+5=20)
        step(1'b1, 4'd4, 32'd15, 4'd0, 4'd4, old);
        step(1'b1, 4'd4, 32'd100, 4'd5, 4'd4, old);
        check("R9 count write wins", rd_data, 32'd100);
        check("R9 no timer event", {24'h0, pend_out}, 32'h0);

        // R8: compare write beats a same-cycle timer event; R6 count still advances
        step(1'b1, 4'd4, 32'd18, 4'd0, 4'd4, old);
        step(1'b1, 4'd5, 32'd50, 4'd5, 4'd4, old);
        check("R6 count advanced during compare write", rd_data, 32'd23);
        check("R8 timer bit stays clear", {24'h0, pend_out}, 32'h0);

        // R7: count already past compare raises nothing
        step(1'b1, 4'd5, 32'd5, 4'd0, 4'd0, old);
        step(1'b0, 4'd0, 32'd0, 4'd9, 4'd0, old);
        check("R7 no event when count above compare", rd_data, 32'h0);

        // R6: counter wraps modulo 2^32
        step(1'b1, 4'd4, 32'hFFFFFFFE, 4'd0, 4'd4, old);
        step(1'b0, 4'd0, 32'd0, 4'd3, 4'd4, old);
        check("R6 wrap", rd_data, 32'd1);

        // R1: reset mid-run clears state again
        step(1'b1, 4'd1, 32'hCAFE0000, 4'd0, 4'd1, old);
        @(negedge clk) rst_n = 1'b0;
        #1 check("R1 EPC cleared by reset", rd_data, 32'h0);
        @(negedge clk) rst_n = 1'b1; rd_addr = 4'd0;
        #1 check("R1 status after reset", rd_data, 32'h1);

        finish_run();
    end
endmodule